// File: doc/BRIEF.md
# Shared-Exponent FP4 Group Quantizer

This block turns a stream of single-precision values into a compact low-bit form. Values arrive one 32-bit word at a time and are collected into groups of eight. For every group the block picks a power-of-two scale from the largest-magnitude member. It then divides each member by that scale and rounds it to a 4-bit floating code with one sign bit, two exponent bits and one mantissa bit. Because each group of eight has its own range setting, a few large outliers elsewhere in a tensor do not crush the resolution of quiet groups.

Each finished group leaves as one 32-bit word holding the eight codes, plus an 8-bit biased scale exponent. Both streams use a valid/ready handshake. A group may be cut short with a last-of-group flag, and the missing members then count as zero. Non-finite inputs mark the whole group as unusable.

Top module: `mx4_block_quant`

## Requirements
- R1: A group closes after the eighth accepted word, or earlier on a word accepted with `in_last` high. Each closed group yields exactly one output, and outputs come out in the order the groups were closed.
- R2: For a group of finite values with at least one nonzero normal member, `out_scale` is the largest biased input exponent minus 2. It is clamped to 0 when that difference would be negative. Input words whose exponent field is 0 count as zero.
- R3: Each 4-bit code is {sign, e1, e0, m}. The magnitude field 3'b000..3'b111 stands for 0, 0.5, 1, 1.5, 2, 3, 4 and 6 times 2^(out_scale-127).
- R4: A scaled magnitude is rounded to the nearest value of that set. An exact tie picks the code whose mantissa bit m is 0.
- R5: Scaled magnitudes above 6 give magnitude field 3'b111 (6).
- R6: The code of the i-th accepted word of a group sits in `out_codes[4*i+3:4*i]`.
- R7: A group whose members are all zero, including negative zero and words with exponent field 0, gives `out_scale` 0 and `out_codes` 0.
- R8: If any member has exponent field 8'hFF (infinite or NaN), `out_scale` is 8'hFF and `out_codes` is 0.
- R9: In a group closed early by `in_last`, the unfilled positions encode as zero (4'h0).
- R10: While `out_valid` is high and `out_ready` is low, `out_codes` and `out_scale` hold steady. `in_ready` stays low from the close of a group until its result is taken.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: A code whose magnitude field is 0 has its sign bit 0, so 4'h8 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 32 | Single-precision input value |
| in_last | input | 1 | Offered word closes its group |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_codes | output | 32 | Eight packed 4-bit codes |
| out_scale | output | 8 | Biased shared scale exponent, 8'hFF = invalid group |

## Verification
Suppose the word counter or the buffer clearing goes wrong. Then the members of one group leak into the next: codes land in the wrong nibble, or stale values appear where padding zeros belong. The scoreboard sees this on the very next result it compares. A wrong peak or scale shows on `out_scale` at once, and it also moves almost every nibble of the same word. A rounding error touches only the codes whose scaled value falls near a midpoint, so the bench sends exact ties, overflow past 6 and sub-half values on purpose. A broken stall path shows up as a changed result word during back-pressure in the cycle after the change.

// File: rtl/mx4_block_quant.sv
module mx4_block_quant #(
  parameter int GROUP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_word,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [4*GROUP-1:0]   out_codes,
  output logic [7:0]           out_scale
);
  localparam int IDX_W  = $clog2(GROUP);
  localparam int CODE_W = 4 * GROUP;

  typedef enum logic [1:0] {S_COLLECT, S_ENCODE, S_HOLD} state_t;

  state_t             st;
  logic [IDX_W-1:0]   cnt;
  logic [31:0]        elems [GROUP];
  logic [7:0]         peak_exp;
  logic               bad;
  logic [7:0]         scale_c;
  logic [CODE_W-1:0]  codes_c;

  assign in_ready = (st == S_COLLECT);

  function automatic logic [3:0] enc(input logic [31:0] x, input logic [7:0] s);
    logic signed [9:0] d;
    logic [22:0]       m;
    logic [2:0]        base;
    logic [2:0]        mag;
    logic [1:0]        ef;
    logic              r;
    m    = x[22:0];
    d    = $signed({2'b00, x[30:23]}) - $signed({2'b00, s});
    mag  = 3'd0;
    ef   = 2'd0;
    base = 3'd0;
    r    = 1'b0;
    if (x[30:23] == 8'd0) begin
      mag = 3'd0;
    end else if (d >= 0) begin
      ef   = d[1:0] + 2'd1;
      base = {ef, m[22]};
      r    = m[21] & ((|m[20:0]) | m[22]);
      mag  = (base == 3'd7) ? 3'd7 : base + {2'b00, r};
    end else if (d == -10'sd1) begin
      mag = 3'd1 + {2'b00, m[22]};
    end else if (d == -10'sd2) begin
      mag = {2'b00, |m};
    end
    return {(mag != 3'd0) & x[31], mag};
  endfunction

  always_comb begin
    peak_exp = 8'd0;
    bad      = 1'b0;
    for (int i = 0; i < GROUP; i++) begin
      if (elems[i][30:23] == 8'hFF) bad = 1'b1;
      else if (elems[i][30:23] > peak_exp) peak_exp = elems[i][30:23];
    end
  end

  assign scale_c = bad ? 8'hFF : (peak_exp < 8'd2) ? 8'd0 : peak_exp - 8'd2;

  always_comb begin
    codes_c = '0;
    for (int i = 0; i < GROUP; i++)
      codes_c[4*i +: 4] = bad ? 4'h0 : enc(elems[i], scale_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_COLLECT;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_codes <= '0;
      out_scale <= '0;
      for (int i = 0; i < GROUP; i++) elems[i] <= '0;
    end else begin
      case (st)
        S_COLLECT: if (in_valid) begin
          elems[cnt] <= in_word;
          if (in_last || cnt == IDX_W'(GROUP - 1)) begin
            cnt <= '0;
            st  <= S_ENCODE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ENCODE: begin
          out_codes <= codes_c;
          out_scale <= scale_c;
          out_valid <= 1'b1;
          st        <= S_HOLD;
        end
        S_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= S_COLLECT;
          for (int i = 0; i < GROUP; i++) elems[i] <= '0;
        end
        default: st <= S_COLLECT;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_codes) && $stable(out_scale));

  assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_bad_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_scale == 8'hFF |-> out_codes == '0);

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid && in_ready);

  assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(!in_ready));

  for (genvar g = 0; g < GROUP; g++) begin : g_zero_sign
    assert_no_neg_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_codes[4*g +: 4] != 4'h8);
  end
endmodule

// File: tb/tb_mx4_block_quant.sv
`timescale 1ns/1ps
module tb_mx4_block_quant;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_word = 0;
  logic        in_last = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_codes;
  logic [7:0]  out_scale;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall_ok = 0;

  logic [39:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] blk [8];

  always #10 clk = ~clk;

  mx4_block_quant dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_codes(out_codes), .out_scale(out_scale)
  );

  function automatic logic [7:0] m_scale();
    int mx = 0;
    for (int i = 0; i < 8; i++) begin
      if (blk[i][30:23] == 8'hFF) return 8'hFF;
      if (int'(blk[i][30:23]) > mx) mx = int'(blk[i][30:23]);
    end
    return (mx < 2) ? 8'd0 : 8'(mx - 2);
  endfunction

  function automatic logic [3:0] m_code(logic [31:0] w, logic [7:0] s);
    longint cand [8] = '{0, 1, 2, 3, 4, 6, 8, 12};
    int d = int'(w[30:23]) - int'(s);
    longint x, mid;
    int c = 0;
    if (w[30:23] == 0 || d < -2) return 4'h0;
    x = longint'({1'b1, w[22:0]}) << (d + 2);
    for (int k = 0; k < 8; k++) if ((cand[k] << 24) <= x) c = k;
    if (c < 7) begin
      mid = ((cand[c] + cand[c+1]) << 24) / 2;
      if (x > mid || (x == mid && c[0])) c = c + 1;
    end
    return (c == 0) ? 4'h0 : {w[31], 3'(c)};
  endfunction

  task automatic send(int n, string tag, int gaps);
    logic [31:0] codes = 0;
    logic [7:0]  sc;
    for (int i = n; i < 8; i++) blk[i] = 32'h0;
    sc = m_scale();
    if (sc != 8'hFF)
      for (int i = 0; i < 8; i++) codes[4*i +: 4] = m_code(blk[i], sc);
    exp_q.push_back({sc, codes});
    tag_q.push_back(tag);
    for (int i = 0; i < n; i++) begin
      repeat (gaps ? $urandom_range(0, 2) : 0) @(negedge clk);
      in_valid = 1;
      in_word  = blk[i];
      in_last  = (i == n - 1) && (n < 8 || $urandom_range(0, 1) == 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0;
      in_last  = 0;
    end
  endtask

  initial begin : monitor
    logic [39:0] prev = 0;
    logic [39:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall_ok) begin
          checks++;
          if (!out_valid || {out_scale, out_codes} !== prev) begin
            errors++;
            $display("FAIL R10 stall: got v=%0b %h expected v=1 %h", out_valid, {out_scale, out_codes}, prev);
          end
        end
        out_ready = ($urandom_range(0, 3) != 0);
        if (out_valid && out_ready) begin
          checks++;
          if (in_ready) begin
            errors++;
            $display("FAIL R10 in_ready high with result pending: got 1 expected 0");
          end
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected result: got %h expected none", {out_scale, out_codes});
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (out_scale !== e[39:32]) begin
              errors++;
              $display("FAIL %s scale: got %h expected %h", t, out_scale, e[39:32]);
            end
            checks++;
            if (out_codes !== e[31:0]) begin
              errors++;
              $display("FAIL %s codes: got %h expected %h", t, out_codes, e[31:0]);
            end
          end
        end
        stall_ok = out_valid && !out_ready;
        prev = {out_scale, out_codes};
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: got v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 after reset: got v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end

    blk = '{32'h3F800000, 32'h40000000, 32'h40400000, 32'h40800000,
            32'h40C00000, 32'h3F000000, 32'hBFC00000, 32'hC0C00000};
    send(8, "R1 R2 R3 R6 basic", 0);

    blk = '{32'h40A00000, 32'h40E00000, 32'h40200000, 32'h40600000,
            32'h3FA00000, 32'h3F400000, 32'h3E800000, 32'h3E4CCCCD};
    send(8, "R4 R5 ties", 0);

    blk = '{32'h40800000, 32'h41000000, 32'hC1200000, 32'h3E000000,
            32'h40F00000, 32'h40D00000, 32'hC0B00000, 32'h3F200000};
    send(8, "R5 R4 saturation", 1);

    blk = '{32'h0, 32'h80000000, 32'h00000001, 32'h807FFFFF,
            32'h0, 32'h0, 32'h0, 32'h0};
    send(8, "R7 zero group", 0);

    blk = '{32'h3F800000, 32'h7FC00000, 32'h40000000, 32'h0,
            32'h0, 32'h0, 32'h0, 32'h0};
    send(8, "R8 NaN", 0);

    blk = '{32'hFF800000, 32'h3F800000, 32'h0, 32'h0,
            32'h0, 32'h0, 32'h0, 32'h0};
    send(2, "R8 R9 infinity short", 0);

    blk = '{32'h40C00000, 32'hBF800000, 32'h40400000, 32'h0,
            32'h0, 32'h0, 32'h0, 32'h0};
    send(3, "R9 R6 short group", 1);

    blk = '{32'hC0400000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    send(1, "R9 R1 single", 0);

    blk = '{32'h40C00000, 32'hBC23D70A, 32'hBE000000, 32'hBE800000,
            32'hBE800001, 32'h80000000, 32'h3F000000, 32'hBF000000};
    send(8, "R12 R4 negative small", 0);

    blk = '{32'h00800000, 32'h00C00000, 32'h80800000, 32'h0,
            32'h0, 32'h0, 32'h0, 32'h0};
    send(8, "R2 clamp", 0);

    blk = '{32'h7F7FFFFF, 32'h7F000000, 32'h7E800000, 32'h7E000000,
            32'hFF7FFFFF, 32'h3F800000, 32'h0, 32'h7EC00000};
    send(8, "R2 R5 top range", 1);

    for (int b = 0; b < 80; b++) begin
      int base = $urandom_range(20, 230);
      int n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 8) : 8;
      for (int i = 0; i < 8; i++) begin
        int e = base - int'($urandom_range(0, 6));
        blk[i] = {1'($urandom_range(0, 1)), 8'(e), 23'($urandom)};
        if ($urandom_range(0, 9) == 0) blk[i] = 32'h0;
      end
      send(n, "R1 R2 R3 R4 R6 R9 random", 1);
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule